// File: doc/BRIEF.md
# Two-Vector Testable Master-Slave D Flip-Flop

This block is a data-width D flip-flop built from two storage stages in series. Each stage is a latch made of two controlled-swap (conservative) gates. The first stage opens while the sampled flop clock `ff_clk` is high, and the second stage opens while it is low. Both stages take the same clock line, so no inverter is needed. The value at `d` during the last high phase shows up on `q` once `ff_clk` falls.

Every stage has its own two-bit control pair. One setting gives plain storage. Two settings break the stage's internal feedback and force every gate output to a known constant. In those test settings, the whole flop is exercised by just two input patterns, all zeros and all ones. A pattern that does not match the chosen setting raises `test_fail`.

The latches are emulated on the system clock `clk`. Each stage keeps its held value in a register that updates on every `clk` edge, and its open path is combinational. The flop clock `ff_clk` is therefore an ordinary data input. The system clock must be fast enough to see every phase of `ff_clk`.

Top module: `ms_dff_rev`

## Requirements
- R1: A synchronous active-high `rst` clears the state of both stages. While `rst` is low after a reset and both pairs are normal, `q` is 0 and `test_fail` is 0.
- R2: With both control pairs at normal (first bit 0, second bit 1, i.e. `2'b01`), `q` takes, from the cycle in which `ff_clk` is first low, the value `d` had in the last `clk` cycle with `ff_clk` high.
- R3: In normal operation, a change of `d` while `ff_clk` is high does not reach `q`, which keeps its last value.
- R4: In normal operation, a change of `d` while `ff_clk` is low does not reach `q`.
- R5: Pair `2'b00` is the stuck-at-1 test setting. The stage's feedback is replaced by a constant 0 and every gate output must be 0. With both stages in this setting, `test_fail` is 0 for the all-zero pattern (`d` all 0, `ff_clk` 0) and 1 when any input is 1.
- R6: Pair `2'b11` is the stuck-at-0 test setting. The feedback is replaced by a constant 1 and every gate output must be 1. With both stages in this setting, `test_fail` is 0 for the all-one pattern (`d` all 1, `ff_clk` 1) and 1 when any input is 0.
- R7: `test_fail` is 0 unless both control pairs are in a test setting (`2'b00` or `2'b11`), whatever the inputs are.
- R8: A stage in a test setting loads its test constant into its state. Back in normal with `ff_clk` low, `q` is all ones after a `2'b11` test and all zeros after a `2'b00` test.
- R9: Pair `2'b10` is reserved. A stage in it keeps its state and output, so `q` does not change while both pairs are `2'b10`, even if `d` and `ff_clk` toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous active-high reset |
| ff_clk | input | 1 | Flop clock; opens the first stage when high and the second when low |
| d | input | DATA_W | Data input |
| m_ctl | input | 2 | First-stage control pair, bit 1 = first control, bit 0 = second |
| s_ctl | input | 2 | Second-stage control pair, same bit order |
| q | output | DATA_W | Flop output |
| test_fail | output | 1 | High when both stages are in test and a gate output differs from the test constant |

## Verification
A wrong held value in the first stage stays hidden while `ff_clk` is high. It reaches `q` in the same cycle that `ff_clk` goes low. A corrupted second-stage state shows on `q` at once during a high phase, so the opaque-phase checks sample `q` in both phases. A fault-flag error is combinational: `test_fail` reacts in the same cycle the pattern is applied. The state loaded during a test only becomes visible after the block returns to normal, so the bench reads it back through `q` with `ff_clk` low.

// File: rtl/ms_dff_rev_pkg.sv
package ms_dff_rev_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_SA1    = 2'd1,
        MODE_SA0    = 2'd2,
        MODE_HOLD   = 2'd3
    } stage_mode_e;

    typedef struct packed {
        logic c1;
        logic c2;
    } ctl_pair_t;

    typedef struct packed {
        logic ctl;
        logic x;
        logic y;
    } cswap_out_t;

    function automatic stage_mode_e decode_mode(input ctl_pair_t p);
        stage_mode_e m;
        case ({p.c1, p.c2})
            2'b01:   m = MODE_NORMAL;
            2'b00:   m = MODE_SA1;
            2'b11:   m = MODE_SA0;
            default: m = MODE_HOLD;
        endcase
        return m;
    endfunction

    function automatic logic is_test(input stage_mode_e m);
        return (m == MODE_SA1) || (m == MODE_SA0);
    endfunction

endpackage

// File: rtl/cswap_cell.sv
module cswap_cell
    import ms_dff_rev_pkg::*;
(
    input  logic       ctl,
    input  logic       a,
    input  logic       b,
    output cswap_out_t o
);

    always_comb begin
        o.ctl = ctl;
        o.x   = ctl ? a : b;
        o.y   = ctl ? b : a;
    end

    // R5 R6: the two-vector test relies on the cell keeping the number of ones
    always_comb begin
        if (!$isunknown({ctl, a, b})) begin
            ones_kept_chk: assert ($countones({o.ctl, o.x, o.y}) == $countones({ctl, a, b}))
                else $error("cswap cell changed the count of ones");
        end
    end

endmodule

// File: rtl/test_latch.sv
module test_latch
    import ms_dff_rev_pkg::*;
#(
    parameter int DATA_W  = 4,
    parameter bit EN_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] d,
    input  ctl_pair_t         ctl,
    output logic [DATA_W-1:0] q,
    output stage_mode_e       mode,
    output logic              fault
);

    localparam int GATE_OUTS = 6;

    logic [DATA_W-1:0] state_q;
    logic [DATA_W-1:0] state_d;
    logic [DATA_W-1:0] fb;
    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] copy;
    logic              in_test;
    logic              en_open;
    cswap_out_t        g1_o [DATA_W];
    cswap_out_t        g2_o [DATA_W];

    assign mode    = decode_mode(ctl);
    assign in_test = is_test(mode);
    assign en_open = EN_HIGH ? en : ~en;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        // in test the feedback line is cut and tied to the pair's constant
        assign fb[i] = in_test ? ctl.c1 : state_q[i];

        if (EN_HIGH) begin : g_pos
            cswap_cell u_sel (.ctl(en), .a(d[i]), .b(fb[i]), .o(g1_o[i]));
        end else begin : g_neg
            cswap_cell u_sel (.ctl(en), .a(fb[i]), .b(d[i]), .o(g1_o[i]));
        end

        assign nxt[i] = g1_o[i].x;

        cswap_cell u_fan (.ctl(nxt[i]), .a(ctl.c1), .b(ctl.c2), .o(g2_o[i]));

        assign copy[i] = g2_o[i].y;
    end

    always_comb begin
        state_d = (mode == MODE_HOLD) ? state_q : copy;
        q       = (mode == MODE_HOLD) ? state_q : copy;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    always_comb begin
        logic [GATE_OUTS-1:0] outs;
        logic                 any_one;
        logic                 any_zero;
        any_one  = 1'b0;
        any_zero = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            outs     = {g1_o[i].ctl, g1_o[i].x, g1_o[i].y,
                        g2_o[i].ctl, g2_o[i].x, g2_o[i].y};
            any_one  = any_one  | (|outs);
            any_zero = any_zero | ~(&outs);
        end
        case (mode)
            MODE_SA1: fault = any_one;
            MODE_SA0: fault = any_zero;
            default:  fault = 1'b0;
        endcase
    end

    // R3 R4
    closed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORMAL && !en_open) |=> $stable(state_q))
        else $error("closed stage changed its state");

    // R9
    reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD) |=> $stable(state_q))
        else $error("reserved setting changed the state");

    // R8
    sa0_load_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SA0) |=> (state_q == {DATA_W{1'b1}}))
        else $error("stuck-at-0 test did not load ones");

    // R8
    sa1_load_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SA1) |=> (state_q == '0))
        else $error("stuck-at-1 test did not load zeros");

    // R2
    open_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORMAL && en_open) |=> (state_q == $past(d)))
        else $error("open stage did not take its input");

endmodule

// File: rtl/ms_dff_rev.sv
module ms_dff_rev
    import ms_dff_rev_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ff_clk,
    input  logic [DATA_W-1:0] d,
    input  logic [1:0]        m_ctl,
    input  logic [1:0]        s_ctl,
    output logic [DATA_W-1:0] q,
    output logic              test_fail
);

    logic [DATA_W-1:0] mid;
    stage_mode_e       m_mode;
    stage_mode_e       s_mode;
    logic              m_fault;
    logic              s_fault;
    logic              both_normal;

    test_latch #(.DATA_W(DATA_W), .EN_HIGH(1'b1)) u_master (
        .clk   (clk),
        .rst   (rst),
        .en    (ff_clk),
        .d     (d),
        .ctl   (ctl_pair_t'(m_ctl)),
        .q     (mid),
        .mode  (m_mode),
        .fault (m_fault)
    );

    test_latch #(.DATA_W(DATA_W), .EN_HIGH(1'b0)) u_slave (
        .clk   (clk),
        .rst   (rst),
        .en    (ff_clk),
        .d     (mid),
        .ctl   (ctl_pair_t'(s_ctl)),
        .q     (q),
        .mode  (s_mode),
        .fault (s_fault)
    );

    assign test_fail   = is_test(m_mode) && is_test(s_mode) && (m_fault || s_fault);
    assign both_normal = (m_mode == MODE_NORMAL) && (s_mode == MODE_NORMAL);

    // R7
    fail_scope_chk: assert property (@(posedge clk) disable iff (rst)
        test_fail |-> (m_ctl != 2'b01 && m_ctl != 2'b10 && s_ctl != 2'b01 && s_ctl != 2'b10))
        else $error("fault flag outside full test setting");

    // R2
    fall_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (both_normal && $past(both_normal) && $past(!rst) && $fell(ff_clk)) |-> (q == $past(d)))
        else $error("falling flop clock did not deliver sampled data");

endmodule

// File: tb/tb_ms_dff_rev.sv
module tb_ms_dff_rev;

    localparam int W = 4;
    localparam logic [1:0] NRM = 2'b01;
    localparam logic [1:0] SA1 = 2'b00;
    localparam logic [1:0] SA0 = 2'b11;
    localparam logic [1:0] RSV = 2'b10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ff_clk = 1'b0;
    logic [W-1:0] d = '0;
    logic [1:0]   m_ctl = NRM;
    logic [1:0]   s_ctl = NRM;
    logic [W-1:0] q;
    logic         test_fail;

    int checks = 0;
    int fails  = 0;

    ms_dff_rev #(.DATA_W(W)) dut (
        .clk(clk), .rst(rst), .ff_clk(ff_clk), .d(d),
        .m_ctl(m_ctl), .s_ctl(s_ctl), .q(q), .test_fail(test_fail)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; m_ctl = NRM; s_ctl = NRM; ff_clk = 1'b0; d = '0;
        step(); step();
        rst = 1'b0;
        #2;
        chk("R1 q after reset", q, '0);
        chk("R1 test_fail after reset", {3'b0, test_fail}, '0);
        step();
    endtask

    task automatic t_normal(input logic [W-1:0] pat);
        m_ctl = NRM; s_ctl = NRM;
        ff_clk = 1'b1; d = pat;
        step();
        ff_clk = 1'b0; d = ~pat;
        #2;
        chk("R2 capture on fall", q, pat);
        step(); step();
        chk("R4 d ignored while low", q, pat);
        ff_clk = 1'b1; d = ~pat;
        step(); step();
        chk("R3 d ignored while high", q, pat);
        ff_clk = 1'b0;
        #2;
        chk("R2 second capture", q, ~pat);
        step();
    endtask

    task automatic t_sa1();
        m_ctl = SA1; s_ctl = SA1; ff_clk = 1'b0; d = '0;
        #2;
        chk("R5 all-zero pattern passes", {3'b0, test_fail}, '0);
        d = 4'b0100;
        #2;
        chk("R5 one data bit set flags", {3'b0, test_fail}, 4'd1);
        d = '0; ff_clk = 1'b1;
        #2;
        chk("R5 clock high flags", {3'b0, test_fail}, 4'd1);
        ff_clk = 1'b0;
        step();
    endtask

    task automatic t_sa0();
        m_ctl = SA0; s_ctl = SA0; ff_clk = 1'b1; d = '1;
        #2;
        chk("R6 all-one pattern passes", {3'b0, test_fail}, '0);
        d = 4'b1101;
        #2;
        chk("R6 one data bit clear flags", {3'b0, test_fail}, 4'd1);
        d = '1; ff_clk = 1'b0;
        #2;
        chk("R6 clock low flags", {3'b0, test_fail}, 4'd1);
        ff_clk = 1'b1;
        step();
    endtask

    task automatic t_scope();
        m_ctl = SA1; s_ctl = NRM; ff_clk = 1'b1; d = '1;
        #2;
        chk("R7 only first stage in test", {3'b0, test_fail}, '0);
        m_ctl = NRM; s_ctl = SA0; ff_clk = 1'b0; d = '0;
        #2;
        chk("R7 only second stage in test", {3'b0, test_fail}, '0);
        m_ctl = RSV; s_ctl = SA0;
        #2;
        chk("R7 reserved plus test", {3'b0, test_fail}, '0);
        m_ctl = NRM; s_ctl = NRM;
        step();
    endtask

    task automatic t_load();
        m_ctl = SA0; s_ctl = SA0; ff_clk = 1'b1; d = '1;
        step();
        m_ctl = NRM; s_ctl = NRM; ff_clk = 1'b0; d = '0;
        #2;
        chk("R8 ones after stuck-at-0 test", q, '1);
        step();
        m_ctl = SA1; s_ctl = SA1; ff_clk = 1'b0; d = '0;
        step();
        m_ctl = NRM; s_ctl = NRM;
        #2;
        chk("R8 zeros after stuck-at-1 test", q, '0);
        step();
    endtask

    task automatic t_hold();
        m_ctl = NRM; s_ctl = NRM; ff_clk = 1'b1; d = 4'h3;
        step();
        ff_clk = 1'b0;
        step();
        m_ctl = RSV; s_ctl = RSV; d = 4'hC;
        for (int i = 0; i < 4; i++) begin
            ff_clk = ~ff_clk;
            step();
            chk("R9 reserved keeps q", q, 4'h3);
        end
        m_ctl = NRM; s_ctl = NRM; ff_clk = 1'b0;
        #2;
        chk("R9 first stage kept state", q, 4'h3);
        step();
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_normal(4'hA);
        t_normal(4'h5);
        t_normal(4'hF);
        t_normal(4'h0);
        t_sa1();
        t_sa0();
        t_scope();
        t_load();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule